// File: doc/BRIEF.md
# ATA Configuration Command Handler

This block is the device-side handler for two ATA configuration commands: SET FEATURES with the set-transfer-mode subcommand, and SET MULTIPLE MODE. It watches host writes to the Features, Sector Count and Command registers. It keeps shadow copies of the parameter registers and validates the requested value during a short busy window. When that window ends it updates either the stored transfer-mode code or the multiple-sector block count. Status is reported through the BSY, ERR and ABRT bits and through a latched completion interrupt.

The sector-transfer engine and the bus-timing logic are outside this block. They read `xfer_mode`, `mult_en` and `mult_cnt` to learn the negotiated transfer type and the block size that READ MULTIPLE and WRITE MULTIPLE use. Fast PIO mode 4 and multiword DMA mode 2 stay usable whatever transfer mode is stored. That rule belongs to the timing logic, so it does not show up at these ports. The controller has three states:

- **IDLE**: waits for a command.
- **CHK0**: the first check cycle.
- **CHK1**: the second check cycle, where the result is applied.

It has three transitions:

- **IDLE to CHK0**: taken when an accepted command code is written.
- **CHK0 to CHK1**: taken unconditionally.
- **CHK1 to IDLE**: the completion, which updates state and raises the interrupt.

Top module: `ata_cfg_cmd`

## Requirements
- R1: After reset, `bsy`, `err`, `abrt` and `intrq` are 0, `xfer_mode` is 0x00 (PIO default), `mult_en` is 0 and `mult_cnt` is 0.
- R2: Command 0xEF with Features holding 0x03 accepts a Sector Count value and stores it in `xfer_mode` with `err`=0 and `abrt`=0. The value's type field is bits 7:3 and its mode field is bits 2:0. The accepted values are:
  - PIO default: type 00000 with mode 0.
  - PIO flow control: type 00001 with mode 0 to 4.
  - Single-word DMA: type 00010 with mode 0 to 2.
  - Multiword DMA: type 00100 with mode 0 to 2.
  - Ultra DMA: type 01000 with mode 0 to 2.
- R3: Any other transfer-mode value sets `err`=1 and `abrt`=1 at completion, and `xfer_mode` keeps its previous value.
- R4: Command 0xC6 with a Sector Count of 2, 4, 8, 16 or 32 sets `mult_en`=1 and `mult_cnt` to that count, with no error.
- R5: Command 0xC6 with any other nonzero Sector Count sets `err`=1 and `abrt`=1, clears `mult_en` and sets `mult_cnt` to 0.
- R6: Command 0xC6 with a Sector Count of 0 clears `mult_en` and `mult_cnt` and reports no error.
- R7: A write of 0xEF or 0xC6 to the Command register while idle raises `bsy` on the next cycle. `bsy` stays high for exactly two cycles, and the results appear in the cycle when `bsy` falls.
- R8: `intrq` goes to 1 in the cycle when `bsy` falls. It holds until a cycle with `stat_rd`=1, and it reads 0 in the following cycle.
- R9: While `bsy`=1, writes to any register are ignored. They change neither the command in progress nor the parameters of later commands.
- R10: Command 0xEF with a Features value other than 0x03 completes with the usual busy window and interrupt, changes no stored state and reports no error. Command codes other than 0xEF and 0xC6 do not raise `bsy`.
- R11: `err` and `abrt` are replaced at every completion, so a command without error clears an earlier abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 Features, 1 Sector Count, 2 Command |
| reg_wdata | input | 8 | Write data |
| stat_rd | input | 1 | Host read of the Status register; acknowledges the interrupt |
| bsy | output | 1 | Busy status bit |
| err | output | 1 | Error status bit |
| abrt | output | 1 | Aborted-command bit of the error register |
| intrq | output | 1 | Pending completion interrupt |
| xfer_mode | output | 8 | Stored transfer-mode code |
| mult_en | output | 1 | READ MULTIPLE and WRITE MULTIPLE enabled |
| mult_cnt | output | 8 | Sectors per block for the multiple-sector commands, 0 when disabled |

## Verification
A command write is captured on edge E0. After that, `bsy` reads 1 after E0 and after E1, and it reads 0 after E2. `xfer_mode`, `mult_en`, `mult_cnt`, `err`, `abrt` and `intrq` all take their new values at E2. A status read captured on an edge clears `intrq` for the sample that follows that edge. The bench drives and samples on falling edges. Each task checks `bsy` on each of the two busy samples and checks the results on the third sample. It checks again one sample later, to confirm that an ignored write started no second command.

// File: rtl/ata_cfg_pkg.sv
package ata_cfg_pkg;

    localparam logic [1:0] SEL_FEAT = 2'd0;
    localparam logic [1:0] SEL_SCNT = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;

    localparam logic [7:0] CMD_SET_FEAT = 8'hEF;
    localparam logic [7:0] CMD_SET_MULT = 8'hC6;
    localparam logic [7:0] SUB_XFER     = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CHK0 = 2'd1,
        ST_CHK1 = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_XFER = 2'd1,
        OP_MULT = 2'd2
    } cfg_op_e;

endpackage

// File: rtl/cfg_shadow_regs.sv
module cfg_shadow_regs
    import ata_cfg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    output logic [DW-1:0] feat_q,
    output logic [DW-1:0] scnt_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feat_q <= '0;
            scnt_q <= '0;
        end else if (wr && !busy) begin
            if (sel == SEL_FEAT) feat_q <= wdata;
            if (sel == SEL_SCNT) scnt_q <= wdata;
        end
    end

endmodule

// File: rtl/xfer_mode_chk.sv
module xfer_mode_chk #(
    parameter int PIO_MAX   = 4,
    parameter int SWDMA_MAX = 2,
    parameter int MWDMA_MAX = 2,
    parameter int UDMA_MAX  = 2
) (
    input  logic [7:0] code,
    output logic       ok
);

    localparam logic [2:0] PIO_LIM = 3'(PIO_MAX);
    localparam logic [2:0] SW_LIM  = 3'(SWDMA_MAX);
    localparam logic [2:0] MW_LIM  = 3'(MWDMA_MAX);
    localparam logic [2:0] UD_LIM  = 3'(UDMA_MAX);

    logic [4:0] kind;
    logic [2:0] num;

    assign kind = code[7:3];
    assign num  = code[2:0];

    always_comb begin
        unique case (kind)
            5'b00000: ok = (num == 3'd0);
            5'b00001: ok = (num <= PIO_LIM);
            5'b00010: ok = (num <= SW_LIM);
            5'b00100: ok = (num <= MW_LIM);
            5'b01000: ok = (num <= UD_LIM);
            default:  ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/blk_cnt_chk.sv
module blk_cnt_chk #(
    parameter int DW      = 8,
    parameter int MIN_LOG = 1,
    parameter int MAX_LOG = 5
) (
    input  logic [DW-1:0] cnt,
    output logic          valid,
    output logic          zero
);

    localparam int NHIT = MAX_LOG - MIN_LOG + 1;

    logic [NHIT-1:0] hit;

    for (genvar i = 0; i < NHIT; i++) begin : g_pow
        localparam int unsigned POW = 1 << (MIN_LOG + i);
        assign hit[i] = (cnt == DW'(POW));
    end

    assign valid = |hit;
    assign zero  = (cnt == '0);

endmodule

// File: rtl/ata_cfg_cmd.sv
module ata_cfg_cmd
    import ata_cfg_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PIO_MAX   = 4,
    parameter int SWDMA_MAX = 2,
    parameter int MWDMA_MAX = 2,
    parameter int UDMA_MAX  = 2,
    parameter int BLK_MIN_LOG = 1,
    parameter int BLK_MAX_LOG = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    input  logic          stat_rd,
    output logic          bsy,
    output logic          err,
    output logic          abrt,
    output logic          intrq,
    output logic [DW-1:0] xfer_mode,
    output logic          mult_en,
    output logic [DW-1:0] mult_cnt
);

    ctl_state_e    state_q, state_d;
    cfg_op_e       op_q;
    logic [DW-1:0] feat_q, scnt_q;
    logic          mode_ok, blk_ok, blk_zero;
    logic          cmd_hit, accept, done;

    cfg_shadow_regs #(.DW(DW)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .busy   (bsy),
        .feat_q (feat_q),
        .scnt_q (scnt_q)
    );

    xfer_mode_chk #(
        .PIO_MAX   (PIO_MAX),
        .SWDMA_MAX (SWDMA_MAX),
        .MWDMA_MAX (MWDMA_MAX),
        .UDMA_MAX  (UDMA_MAX)
    ) u_mode (
        .code (scnt_q[7:0]),
        .ok   (mode_ok)
    );

    blk_cnt_chk #(
        .DW      (DW),
        .MIN_LOG (BLK_MIN_LOG),
        .MAX_LOG (BLK_MAX_LOG)
    ) u_blk (
        .cnt   (scnt_q),
        .valid (blk_ok),
        .zero  (blk_zero)
    );

    assign cmd_hit = (reg_wdata[7:0] == CMD_SET_FEAT) || (reg_wdata[7:0] == CMD_SET_MULT);
    assign accept  = reg_wr && (reg_sel == SEL_CMD) && cmd_hit && (state_q == ST_IDLE);
    assign done    = (state_q == ST_CHK1);
    assign bsy     = (state_q != ST_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_CHK0;
            ST_CHK0: state_d = ST_CHK1;
            ST_CHK1: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NOP;
        end else begin
            state_q <= state_d;
            if (accept) begin
                if (reg_wdata[7:0] == CMD_SET_MULT) op_q <= OP_MULT;
                else if (feat_q[7:0] == SUB_XFER)   op_q <= OP_XFER;
                else                                op_q <= OP_NOP;
            end
        end
    end

    // outputs, applied at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err       <= 1'b0;
            abrt      <= 1'b0;
            intrq     <= 1'b0;
            xfer_mode <= '0;
            mult_en   <= 1'b0;
            mult_cnt  <= '0;
        end else if (done) begin
            intrq <= 1'b1;
            unique case (op_q)
                OP_XFER: begin
                    err  <= !mode_ok;
                    abrt <= !mode_ok;
                    if (mode_ok) xfer_mode <= scnt_q;
                end
                OP_MULT: begin
                    err      <= !blk_ok && !blk_zero;
                    abrt     <= !blk_ok && !blk_zero;
                    mult_en  <= blk_ok;
                    mult_cnt <= blk_ok ? scnt_q : '0;
                end
                default: begin
                    err  <= 1'b0;
                    abrt <= 1'b0;
                end
            endcase
        end else if (stat_rd) begin
            intrq <= 1'b0;
        end
    end

endmodule

// File: rtl/ata_cfg_cmd_chk.sv
module ata_cfg_cmd_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_sel,
    input logic [DW-1:0] reg_wdata,
    input logic          stat_rd,
    input logic          bsy,
    input logic          err,
    input logic          abrt,
    input logic          intrq,
    input logic [DW-1:0] xfer_mode,
    input logic          mult_en,
    input logic [DW-1:0] mult_cnt
);

    assert_bsy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2 && !bsy &&
         (reg_wdata[7:0] == 8'hEF || reg_wdata[7:0] == 8'hC6)) |=> bsy);

    assert_bsy_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy) |=> bsy ##1 !bsy);

    assert_abrt_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abrt |-> err);

    assert_mult_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mult_en |-> ($countones(mult_cnt) == 1 && mult_cnt >= DW'(2)));

    assert_mult_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mult_en |-> (mult_cnt == '0));

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bsy) |-> ($stable(xfer_mode) && $stable(mult_en) && $stable(err)));

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intrq) |-> $fell(bsy));

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (intrq && !stat_rd && bsy == 1'b0) |=> intrq);

endmodule

bind ata_cfg_cmd ata_cfg_cmd_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .stat_rd   (stat_rd),
    .bsy       (bsy),
    .err       (err),
    .abrt      (abrt),
    .intrq     (intrq),
    .xfer_mode (xfer_mode),
    .mult_en   (mult_en),
    .mult_cnt  (mult_cnt)
);

// File: tb/sim_ata_cfg_cmd.sv
module sim_ata_cfg_cmd;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       stat_rd = 1'b0;
    logic       bsy, err, abrt, intrq, mult_en;
    logic [7:0] xfer_mode, mult_cnt;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ata_cfg_cmd u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .stat_rd   (stat_rd),
        .bsy       (bsy),
        .err       (err),
        .abrt      (abrt),
        .intrq     (intrq),
        .xfer_mode (xfer_mode),
        .mult_en   (mult_en),
        .mult_cnt  (mult_cnt)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    // one register write; returns at the falling edge after the capturing edge
    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // issue a command and walk through the busy window; returns at the result sample
    task automatic run_cmd(input string req, input logic [7:0] code);
        wr_reg(2'd2, code);
        check("R7", {req, " bsy cycle1"}, bsy, 1);
        @(negedge clk);
        check("R7", {req, " bsy cycle2"}, bsy, 1);
        @(negedge clk);
        check("R7", {req, " bsy released"}, bsy, 0);
        check("R8", {req, " intrq at completion"}, intrq, 1);
    endtask

    task automatic ack_irq();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic set_mode(input string req, input logic [7:0] code);
        wr_reg(2'd0, 8'h03);
        wr_reg(2'd1, code);
        run_cmd(req, 8'hEF);
        ack_irq();
    endtask

    task automatic t_reset();
        check("R1", "bsy", bsy, 0);
        check("R1", "err", err, 0);
        check("R1", "abrt", abrt, 0);
        check("R1", "intrq", intrq, 0);
        check("R1", "xfer_mode", xfer_mode, 0);
        check("R1", "mult_en", mult_en, 0);
        check("R1", "mult_cnt", mult_cnt, 0);
    endtask

    task automatic t_valid_modes();
        logic [7:0] list [16] = '{8'h00, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
                                  8'h10, 8'h11, 8'h12, 8'h20, 8'h21, 8'h22,
                                  8'h40, 8'h41, 8'h42, 8'h0C};
        for (int i = 0; i < 16; i++) begin
            wr_reg(2'd0, 8'h03);
            wr_reg(2'd1, list[i]);
            run_cmd("R2", 8'hEF);
            check("R2", "xfer_mode accepted", xfer_mode, list[i]);
            check("R2", "err clear", err, 0);
            check("R2", "abrt clear", abrt, 0);
            ack_irq();
        end
    endtask

    task automatic t_bad_modes();
        logic [7:0] list [8] = '{8'h0D, 8'h13, 8'h23, 8'h43, 8'h18, 8'h80, 8'h01, 8'h0F};
        set_mode("R2", 8'h21);
        for (int i = 0; i < 8; i++) begin
            wr_reg(2'd0, 8'h03);
            wr_reg(2'd1, list[i]);
            run_cmd("R3", 8'hEF);
            check("R3", "xfer_mode kept", xfer_mode, 8'h21);
            check("R3", "err set", err, 1);
            check("R3", "abrt set", abrt, 1);
            ack_irq();
        end
    endtask

    task automatic t_mult_valid();
        for (int s = 1; s <= 5; s++) begin
            wr_reg(2'd1, 8'(1 << s));
            run_cmd("R4", 8'hC6);
            check("R4", "mult_en", mult_en, 1);
            check("R4", "mult_cnt", mult_cnt, 1 << s);
            check("R4", "err clear", err, 0);
            ack_irq();
        end
    endtask

    task automatic t_mult_bad();
        logic [7:0] list [5] = '{8'h03, 8'h40, 8'h01, 8'h06, 8'hFF};
        for (int i = 0; i < 5; i++) begin
            wr_reg(2'd1, 8'h08);
            run_cmd("R4", 8'hC6);
            ack_irq();
            wr_reg(2'd1, list[i]);
            run_cmd("R5", 8'hC6);
            check("R5", "mult_en off", mult_en, 0);
            check("R5", "mult_cnt zero", mult_cnt, 0);
            check("R5", "err set", err, 1);
            check("R5", "abrt set", abrt, 1);
            ack_irq();
        end
    endtask

    task automatic t_mult_zero();
        wr_reg(2'd1, 8'h10);
        run_cmd("R4", 8'hC6);
        ack_irq();
        wr_reg(2'd1, 8'h00);
        run_cmd("R6", 8'hC6);
        check("R6", "mult_en off", mult_en, 0);
        check("R6", "mult_cnt zero", mult_cnt, 0);
        check("R6", "err clear", err, 0);
        check("R6", "abrt clear", abrt, 0);
        ack_irq();
    endtask

    task automatic t_irq();
        wr_reg(2'd1, 8'h04);
        run_cmd("R8", 8'hC6);
        repeat (5) @(negedge clk);
        check("R8", "intrq held", intrq, 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R8", "intrq cleared by status read", intrq, 0);
    endtask

    task automatic t_busy_ignore();
        wr_reg(2'd1, 8'h02);
        run_cmd("R4", 8'hC6);
        ack_irq();
        wr_reg(2'd1, 8'h20);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 8'hC6;
        @(negedge clk);
        check("R9", "bsy cycle1", bsy, 1);
        reg_sel = 2'd1; reg_wdata = 8'h04;
        @(negedge clk);
        check("R9", "bsy cycle2", bsy, 1);
        reg_sel = 2'd2; reg_wdata = 8'hC6;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R9", "bsy released", bsy, 0);
        check("R9", "count from pre-busy value", mult_cnt, 8'h20);
        @(negedge clk);
        check("R9", "no second command", bsy, 0);
        ack_irq();
        run_cmd("R9", 8'hC6);
        check("R9", "sector count not overwritten", mult_cnt, 8'h20);
        ack_irq();
    endtask

    task automatic t_other();
        set_mode("R2", 8'h41);
        wr_reg(2'd0, 8'h02);
        wr_reg(2'd1, 8'h0C);
        run_cmd("R10", 8'hEF);
        check("R10", "xfer_mode untouched", xfer_mode, 8'h41);
        check("R10", "err clear", err, 0);
        ack_irq();
        wr_reg(2'd2, 8'h20);
        check("R10", "unknown command no bsy", bsy, 0);
        @(negedge clk);
        check("R10", "unknown command no intrq", intrq, 0);
    endtask

    task automatic t_err_clear();
        wr_reg(2'd1, 8'h05);
        run_cmd("R5", 8'hC6);
        check("R11", "err after abort", err, 1);
        ack_irq();
        wr_reg(2'd1, 8'h20);
        run_cmd("R11", 8'hC6);
        check("R11", "err cleared", err, 0);
        check("R11", "abrt cleared", abrt, 0);
        ack_irq();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_valid_modes();
        t_bad_modes();
        t_mult_valid();
        t_mult_bad();
        t_mult_zero();
        t_irq();
        t_busy_ignore();
        t_other();
        t_err_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule